// File: doc/BRIEF.md
# Serial Channel Bit-Clock Selector and Baud Rate Generator

This block produces the bit-rate clock enables for one channel of a serial controller. It runs entirely on the system clock `clk`, which also serves as the processor clock source. Four timing sources are available. The first is the RTxC pin, or a crystal oscillator tick that replaces it. The second is the TRxC pin. The third is the processor clock, which ticks on every `clk` cycle. The fourth is a tick from a phase-locked recovery stage that is not part of this block. The two pin inputs are asynchronous levels: each is synchronised and reduced to one tick per rising edge.

A 16-bit down-counting baud rate generator divides either the RTxC source or the processor clock. Its output toggles at every terminal count, so one full output period is 2×(TC+2) source ticks, where TC is the time constant. The transmit path and the receive path each pick one of four sources. Each then passes through a shared oversampling divider of ×1, ×16, ×32 or ×64 to give `tx_clk_en` and `rx_clk_en`. The TRxC pin can be turned into an output that carries one of four clocks. A sticky flag records each terminal count of the generator.

The division rules for each source follow from this structure. The TRxC pin can only be divided directly, by the oversampling factor. The processor clock can only be divided through the generator, so its total division is an even number of at least 4 times the oversampling factor. RTxC can be divided either way.

Top module: `serclk_gen`

## Requirements
- R1: While `rst_n` is low and after its release with all controls at zero, `tx_clk_en`, `rx_clk_en`, `trxc_out` and `brg_zero` are 0.
- R2: The transmit source is `clk_ctrl[4:3]` and the receive source is `clk_ctrl[6:5]`, chosen independently. In both fields 00 selects the RTxC source, 01 the TRxC pin rising edges, 10 the generator output rising edges and 11 `dpll_tick`.
- R3: `clk_mode` (00=×1, 01=×16, 10=×32, 11=×64) sets the number of selected source ticks per pulse on `tx_clk_en` and `rx_clk_en`. Each pulse lasts one cycle.
- R4: With `brg_ctrl[0]`=1 the generator produces one output rising edge every 2×(TC+2) source ticks, where TC = {`tc_hi`,`tc_lo`}. Its source is every `clk` cycle when `brg_ctrl[1]`=1 and the RTxC source when `brg_ctrl[1]`=0.
- R5: The RTxC source gives one tick per rising edge of `rtxc_pin` after synchronisation. When `clk_ctrl[7]`=1 it uses `xtal_tick` instead and ignores the pin.
- R6: A time constant written while the generator runs does not change the half period in progress. The next half period uses the new value.
- R7: With `brg_ctrl[0]`=0 the generator gives no output edges and never sets `brg_zero`. A generator-sourced clock then stays silent.
- R8: `brg_zero` is set at every terminal count of the running generator and stays set until `zero_ack` is high in a cycle without a new terminal count. `brg_irq` is `brg_zero` AND `zero_int_en`.
- R9: `trxc_oe` equals `clk_ctrl[2]`. While it is 1, `trxc_out` pulses once, one cycle later, for each tick of the source picked by `clk_ctrl[1:0]`: 00 `xtal_tick`, 01 the transmit source before oversampling, 10 the generator output edge, 11 `dpll_tick`. While it is 0, `trxc_out` stays 0.
- R10: Selecting code 11 for a direction passes every `dpll_tick` to that direction's oversampling divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the processor clock source |
| rst_n | input | 1 | Synchronous active-low reset |
| rtxc_pin | input | 1 | RTxC pin level, asynchronous |
| trxc_pin | input | 1 | TRxC pin level, asynchronous |
| xtal_tick | input | 1 | One-cycle tick from the crystal oscillator |
| dpll_tick | input | 1 | One-cycle tick standing in for the recovered clock |
| clk_ctrl | input | 8 | Clock routing field set (see R2, R5, R9) |
| brg_ctrl | input | 2 | Bit 0 generator enable, bit 1 processor-clock source |
| clk_mode | input | 2 | Oversampling factor code |
| zero_int_en | input | 1 | Interrupt enable for the terminal-count flag |
| tc_lo | input | 8 | Time constant, low byte |
| tc_hi | input | 8 | Time constant, high byte |
| zero_ack | input | 1 | Clears the terminal-count flag |
| tx_clk_en | output | 1 | Transmit bit-clock enable pulse |
| rx_clk_en | output | 1 | Receive bit-clock enable pulse |
| trxc_out | output | 1 | Clock pulses driven onto the TRxC pin |
| trxc_oe | output | 1 | TRxC pin output enable |
| brg_zero | output | 1 | Sticky terminal-count flag |
| brg_irq | output | 1 | Terminal-count interrupt request |

## Verification
The assertions check the following on every cycle. The counter decrements by exactly one per source tick and holds between ticks, even while the time constant changes. Each clock-enable pulse is preceded by a source tick. Each synchronised pin edge yields a single tick. The flag rises only after a terminal count and holds until acknowledged. The pin output is silent unless enabled. Only the bench scenarios can show the end-to-end rates: pulse intervals for each source, oversampling factor and time constant, the exact mixed-length period around a time-constant change, and silence while the generator is disabled.

// File: rtl/serclk_pkg.sv
// Shared encodings and helpers for the serial bit-clock block.
// Assumes all clock sources arrive as one-cycle ticks in the clk domain.
package serclk_pkg;

    // Width of the oversampling counter (largest factor is 64).
    localparam int OVS_CNT_W = 6;

    // Direction clock source codes.
    typedef enum logic [1:0] {
        SRC_RTXC = 2'b00,
        SRC_TRXC = 2'b01,
        SRC_BRG  = 2'b10,
        SRC_DPLL = 2'b11
    } clk_src_e;

    // Oversampling factor codes.
    typedef enum logic [1:0] {
        OVS_X1  = 2'b00,
        OVS_X16 = 2'b01,
        OVS_X32 = 2'b10,
        OVS_X64 = 2'b11
    } ovs_e;

    // Last counter value before wrap for a given oversampling code.
    function automatic logic [OVS_CNT_W-1:0] ovs_last(input logic [1:0] code);
        case (ovs_e'(code))
            OVS_X1:  return OVS_CNT_W'(0);
            OVS_X16: return OVS_CNT_W'(15);
            OVS_X32: return OVS_CNT_W'(31);
            default: return OVS_CNT_W'(63);
        endcase
    endfunction

    // Four-way tick selector shared by every clock mux.
    function automatic logic pick_tick(input logic [1:0] sel, input logic t0,
                                       input logic t1, input logic t2, input logic t3);
        case (sel)
            2'b00:   return t0;
            2'b01:   return t1;
            2'b10:   return t2;
            default: return t3;
        endcase
    endfunction

endpackage

// File: rtl/serclk_edge_sync.sv
// Synchronises an asynchronous pin level and emits a one-cycle tick per
// rising edge. Assumes the pin stays stable for at least two clk cycles.
module serclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh;

    // Shift the pin through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R5: one pin edge never gives two back-to-back ticks.
    assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/serclk_brg.sv
// Down-counting baud rate generator. On each source tick the counter
// decrements; at zero it reloads TC+1 and toggles its output, giving a
// half period of TC+2 ticks. The time constant is sampled only at reload.
// Assumes src_tick is a one-cycle enable in the clk domain.
module serclk_brg #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            src_tick,
    input  logic [TC_W-1:0] tc,
    output logic            brg_tick,
    output logic            zero_evt
);
    localparam int CNT_W = TC_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic             level;
    logic             at_term;

    assign reload   = {1'b0, tc} + CNT_W'(1);
    assign at_term  = (cnt == '0);
    assign zero_evt = enable & src_tick & at_term;
    assign brg_tick = zero_evt & ~level;

    // Count source ticks, reload and toggle at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (!enable) begin
            cnt   <= reload;
            level <= 1'b0;
        end else if (src_tick) begin
            if (at_term) begin
                cnt   <= reload;
                level <= ~level;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // R4: a running counter steps down by exactly one per tick.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && src_tick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R6: without a tick the count holds, whatever happens to the time constant.
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !src_tick) |=> $stable(cnt));

    // R7: the output only rises when enabled and ticking.
    assert_rise_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> $past(enable && src_tick));
endmodule

// File: rtl/serclk_ovs.sv
// Oversampling divider: passes one of every 1, 16, 32 or 64 source ticks
// as a registered one-cycle clock enable. Assumes mode changes are rare;
// a shrinking factor wraps at the next tick.
module serclk_ovs
    import serclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       src_tick,
    output logic       clk_en
);
    logic [OVS_CNT_W-1:0] cnt;
    logic [OVS_CNT_W-1:0] last;

    assign last = ovs_last(mode);

    // Count source ticks and emit a pulse at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            clk_en <= 1'b0;
        end else begin
            clk_en <= 1'b0;
            if (src_tick) begin
                if (cnt >= last) begin
                    cnt    <= '0;
                    clk_en <= 1'b1;
                end else begin
                    cnt <= cnt + OVS_CNT_W'(1);
                end
            end
        end
    end

    // R3: every pulse follows a source tick.
    assert_pulse_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> $past(src_tick));

    // R3: in x1 mode each tick passes through.
    assert_x1_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && src_tick) |=> clk_en);
endmodule

// File: rtl/serclk_gen.sv
// Bit-clock selection and baud generation for one serial channel.
// Routes four timing sources to the transmit path, receive path and TRxC
// pin, divides through the baud generator and oversampling dividers, and
// keeps a sticky terminal-count flag. Assumes the processor clock is clk.
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int TC_BYTE_W   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rtxc_pin,
    input  logic                 trxc_pin,
    input  logic                 xtal_tick,
    input  logic                 dpll_tick,
    input  logic [7:0]           clk_ctrl,
    input  logic [1:0]           brg_ctrl,
    input  logic [1:0]           clk_mode,
    input  logic                 zero_int_en,
    input  logic [TC_BYTE_W-1:0] tc_lo,
    input  logic [TC_BYTE_W-1:0] tc_hi,
    input  logic                 zero_ack,
    output logic                 tx_clk_en,
    output logic                 rx_clk_en,
    output logic                 trxc_out,
    output logic                 trxc_oe,
    output logic                 brg_zero,
    output logic                 brg_irq
);
    localparam int TC_W    = 2 * TC_BYTE_W;
    localparam int NUM_PIN = 2;
    localparam int NUM_DIR = 2;

    logic [NUM_PIN-1:0] pin_lvl;
    logic [NUM_PIN-1:0] pin_rise;
    logic               rtxc_tick;
    logic               trxc_tick;
    logic               brg_src_tick;
    logic               brg_tick;
    logic               brg_zero_evt;
    logic [1:0]         dir_sel [NUM_DIR];
    logic [NUM_DIR-1:0] dir_src;
    logic [NUM_DIR-1:0] dir_en;
    logic               pin_src;

    // Pin synchronisers, one per input pin.
    assign pin_lvl = {trxc_pin, rtxc_pin};
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        serclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_lvl[p]),
            .rise  (pin_rise[p])
        );
    end

    // RTxC source: crystal tick in crystal mode, otherwise the pin edge.
    assign rtxc_tick    = clk_ctrl[7] ? xtal_tick : pin_rise[0];
    assign trxc_tick    = pin_rise[1];
    assign brg_src_tick = brg_ctrl[1] ? 1'b1 : rtxc_tick;

    serclk_brg #(.TC_W(TC_W)) u_brg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (brg_ctrl[0]),
        .src_tick (brg_src_tick),
        .tc       ({tc_hi, tc_lo}),
        .brg_tick (brg_tick),
        .zero_evt (brg_zero_evt)
    );

    // Direction selects: transmit then receive.
    assign dir_sel[0] = clk_ctrl[4:3];
    assign dir_sel[1] = clk_ctrl[6:5];

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        assign dir_src[d] = pick_tick(dir_sel[d], rtxc_tick, trxc_tick, brg_tick, dpll_tick);
        serclk_ovs u_ovs (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (clk_mode),
            .src_tick (dir_src[d]),
            .clk_en   (dir_en[d])
        );
    end

    assign tx_clk_en = dir_en[0];
    assign rx_clk_en = dir_en[1];

    // TRxC pin drive.
    assign trxc_oe = clk_ctrl[2];
    assign pin_src = pick_tick(clk_ctrl[1:0], xtal_tick, dir_src[0], brg_tick, dpll_tick);

    // Register the pin clock, gated by the output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) trxc_out <= 1'b0;
        else        trxc_out <= trxc_oe & pin_src;
    end

    // Sticky terminal-count flag; a new count wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)            brg_zero <= 1'b0;
        else if (brg_zero_evt) brg_zero <= 1'b1;
        else if (zero_ack)     brg_zero <= 1'b0;
    end

    assign brg_irq = brg_zero & zero_int_en;

    // R9: the pin is quiet unless it was enabled as an output.
    assert_pin_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trxc_out |-> $past(trxc_oe));

    // R8: the flag rises only after a terminal count.
    assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brg_zero) |-> $past(brg_zero_evt));

    // R8: the flag holds until acknowledged.
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (brg_zero && !zero_ack) |=> brg_zero);

    // R7: a disabled generator never raises the flag.
    assert_no_flag_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!brg_ctrl[0] && !brg_zero) |=> !brg_zero);
endmodule

// File: tb/serclk_gen_test.sv
`timescale 1ns/1ps
module serclk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rtxc_pin, trxc_pin, xtal_tick, dpll_tick;
    logic [7:0] clk_ctrl;
    logic [1:0] brg_ctrl, clk_mode;
    logic       zero_int_en, zero_ack;
    logic [7:0] tc_lo, tc_hi;
    logic       tx_clk_en, rx_clk_en, trxc_out, trxc_oe, brg_zero, brg_irq;

    int n_chk = 0;
    int n_fail = 0;
    int rtxc_half = 0, trxc_half = 0, xtal_per = 0, dpll_per = 0;

    always #2 clk = ~clk;

    serclk_gen uut (
        .clk(clk), .rst_n(rst_n), .rtxc_pin(rtxc_pin), .trxc_pin(trxc_pin),
        .xtal_tick(xtal_tick), .dpll_tick(dpll_tick), .clk_ctrl(clk_ctrl),
        .brg_ctrl(brg_ctrl), .clk_mode(clk_mode), .zero_int_en(zero_int_en),
        .tc_lo(tc_lo), .tc_hi(tc_hi), .zero_ack(zero_ack),
        .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en), .trxc_out(trxc_out),
        .trxc_oe(trxc_oe), .brg_zero(brg_zero), .brg_irq(brg_irq)
    );

    // Stimulus sources: pin toggles and periodic ticks, driven at negedge.
    initial begin
        int c1, c2, c3, c4;
        c1 = 0; c2 = 0; c3 = 0; c4 = 0;
        rtxc_pin = 1'b0; trxc_pin = 1'b0; xtal_tick = 1'b0; dpll_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (rtxc_half > 0) begin c1++; if (c1 >= rtxc_half) begin c1 = 0; rtxc_pin = ~rtxc_pin; end end
            if (trxc_half > 0) begin c2++; if (c2 >= trxc_half) begin c2 = 0; trxc_pin = ~trxc_pin; end end
            xtal_tick = 1'b0;
            if (xtal_per > 0) begin c3++; if (c3 >= xtal_per) begin c3 = 0; xtal_tick = 1'b1; end end
            dpll_tick = 1'b0;
            if (dpll_per > 0) begin c4++; if (c4 >= dpll_per) begin c4 = 0; dpll_tick = 1'b1; end end
        end
    end

    // Scoreboard: expected intervals per channel (0 tx, 1 rx, 2 pin).
    int    exp_q [3][$];
    string tag_q [3][$];
    bit    armed [3];
    int    since [3];

    // Monitor: measure full intervals between pulses and compare.
    always @(negedge clk) begin
        logic [2:0] s;
        s = {trxc_out, rx_clk_en, tx_clk_en};
        for (int ch = 0; ch < 3; ch++) begin
            if (s[ch]) begin
                if (armed[ch] && exp_q[ch].size() > 0) begin
                    n_chk++;
                    if (since[ch] + 1 != exp_q[ch][0]) begin
                        n_fail++;
                        $display("FAIL %s ch%0d interval: got %0d expected %0d",
                                 tag_q[ch][0], ch, since[ch] + 1, exp_q[ch][0]);
                    end
                    void'(exp_q[ch].pop_front());
                    void'(tag_q[ch].pop_front());
                    armed[ch] = 1'b0;
                end else if (exp_q[ch].size() > 0) begin
                    armed[ch] = 1'b1;
                end
                since[ch] = 0;
            end else begin
                since[ch]++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic expect_rate(input int ch, input int iv, input string tag);
        exp_q[ch].push_back(iv);
        tag_q[ch].push_back(tag);
    endtask

    task automatic drain(input int limit);
        int t;
        t = 0;
        while ((exp_q[0].size() + exp_q[1].size() + exp_q[2].size()) > 0 && t < limit) begin
            @(negedge clk);
            t++;
        end
        for (int ch = 0; ch < 3; ch++) begin
            while (exp_q[ch].size() > 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s ch%0d interval: got none expected %0d", tag_q[ch][0], ch, exp_q[ch][0]);
                void'(exp_q[ch].pop_front());
                void'(tag_q[ch].pop_front());
                armed[ch] = 1'b0;
            end
        end
    endtask

    task automatic expect_silent(input int ch, input int cycles, input string tag);
        int cnt;
        cnt = 0;
        repeat (cycles) begin
            @(negedge clk);
            if ((ch == 0 && tx_clk_en) || (ch == 1 && rx_clk_en) || (ch == 2 && trxc_out)) cnt++;
        end
        check(cnt == 0, tag, cnt, 0);
    endtask

    task automatic setup(input logic [7:0] cc, input logic [1:0] bc, input logic [1:0] md,
                         input logic [15:0] tc);
        clk_ctrl = cc; brg_ctrl = bc; clk_mode = md;
        tc_hi = tc[15:8]; tc_lo = tc[7:0];
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        for (int ch = 0; ch < 3; ch++) begin armed[ch] = 1'b0; since[ch] = 0; end
        rst_n = 1'b0; zero_ack = 1'b0; zero_int_en = 1'b0;
        setup(8'h00, 2'b00, 2'b00, 16'h0000);
        settle(4);
        // R1: outputs low during reset
        check({tx_clk_en, rx_clk_en, trxc_out, brg_zero} == 4'b0, "R1 in reset",
              int'({tx_clk_en, rx_clk_en, trxc_out, brg_zero}), 0);
        rst_n = 1'b1;
        settle(20);
        check({tx_clk_en, rx_clk_en, trxc_out, brg_zero} == 4'b0, "R1 after release",
              int'({tx_clk_en, rx_clk_en, trxc_out, brg_zero}), 0);

        // R4: processor clock through generator, TC=3, all to generator, x1
        setup(8'h56, 2'b11, 2'b00, 16'd3);
        settle(200);
        expect_rate(0, 10, "R4 tx tc3"); expect_rate(1, 10, "R4 rx tc3"); expect_rate(2, 10, "R9 pin brg");
        drain(200);

        // R4: high byte of the time constant counts
        setup(8'h56, 2'b11, 2'b00, 16'h0100);
        settle(1700);
        expect_rate(0, 516, "R4 tx tc256");
        drain(2000);

        // R3: oversampling factors
        setup(8'h56, 2'b11, 2'b01, 16'd1);
        settle(900);
        expect_rate(0, 96, "R3 x16 tx"); expect_rate(1, 96, "R3 x16 rx");
        drain(400);
        setup(8'h56, 2'b11, 2'b10, 16'd1);
        settle(800);
        expect_rate(0, 192, "R3 x32 tx");
        drain(600);
        setup(8'h56, 2'b11, 2'b11, 16'd0);
        settle(800);
        expect_rate(0, 256, "R3 x64 tx"); expect_rate(2, 4, "R9 pin not oversampled");
        drain(800);

        // R2: independent pin sources per direction
        rtxc_half = 4; trxc_half = 3;
        setup(8'h20, 2'b11, 2'b01, 16'd1);
        settle(900);
        expect_rate(0, 128, "R2 tx rtxc"); expect_rate(1, 96, "R2 rx trxc");
        drain(500);

        // R5: crystal replaces the RTxC pin
        xtal_per = 10;
        setup(8'h80, 2'b11, 2'b00, 16'd1);
        settle(100);
        expect_rate(0, 10, "R5 tx xtal"); expect_rate(1, 10, "R5 rx xtal");
        drain(200);

        // R4: generator sourced from RTxC pin (8-cycle period), TC=1
        setup(8'h10, 2'b01, 2'b00, 16'd1);
        settle(300);
        expect_rate(0, 48, "R4 brg from rtxc");
        drain(300);

        // R10 and R9: recovered clock on both paths and the pin
        dpll_per = 7;
        setup(8'h7D, 2'b11, 2'b00, 16'd1);
        settle(100);
        expect_rate(0, 7, "R10 tx dpll"); expect_rate(1, 7, "R10 rx dpll"); expect_rate(2, 7, "R9 pin txclk");
        drain(200);
        setup(8'h7F, 2'b11, 2'b00, 16'd1);
        settle(50);
        expect_rate(2, 7, "R9 pin dpll");
        drain(200);
        xtal_per = 12;
        setup(8'h7C, 2'b11, 2'b00, 16'd1);
        settle(50);
        expect_rate(2, 12, "R9 pin xtal");
        check(trxc_oe == 1'b1, "R9 oe on", int'(trxc_oe), 1);
        drain(200);
        setup(8'h78, 2'b11, 2'b00, 16'd1);
        settle(3);
        check(trxc_oe == 1'b0, "R9 oe off", int'(trxc_oe), 0);
        expect_silent(2, 100, "R9 pin silent");

        // R6: time constant change mid half-period
        setup(8'h10, 2'b11, 2'b00, 16'd20);
        settle(200);
        do @(negedge clk); while (!tx_clk_en);
        tc_lo = 8'd5;
        n = 0;
        do begin @(negedge clk); n++; end while (!tx_clk_en && n < 500);
        check(n == 29, "R6 mixed period", n, 29);
        expect_rate(0, 14, "R6 new period");
        drain(200);

        // R7: disabled generator is silent and sets no flag
        brg_ctrl = 2'b10;
        zero_ack = 1'b1;
        settle(1);
        zero_ack = 1'b0;
        settle(5);
        expect_silent(0, 300, "R7 tx silent");
        check(brg_zero == 1'b0, "R7 no flag", int'(brg_zero), 0);

        // R8: flag set, interrupt gating, acknowledge
        brg_ctrl = 2'b11; tc_lo = 8'd3;
        settle(20);
        check(brg_zero == 1'b1, "R8 flag set", int'(brg_zero), 1);
        check(brg_irq == 1'b0, "R8 irq masked", int'(brg_irq), 0);
        zero_int_en = 1'b1;
        settle(1);
        check(brg_irq == 1'b1, "R8 irq enabled", int'(brg_irq), 1);
        tc_hi = 8'h03; tc_lo = 8'hE8;
        settle(30);
        zero_ack = 1'b1;
        settle(1);
        zero_ack = 1'b0;
        check(brg_zero == 1'b0, "R8 flag cleared", int'(brg_zero), 0);
        check(brg_irq == 1'b0, "R8 irq cleared", int'(brg_irq), 0);
        settle(1100);
        check(brg_zero == 1'b1, "R8 flag set again", int'(brg_zero), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule